// File: doc/BRIEF.md
# Latched Addressable Bus Port

This block sits on the peripheral side of a shared 8-bit bus that carries both addresses and data. Two strobes, an address strobe and a write strobe, classify every clock cycle, and a bank line names which of two banks (left or right) the cycle is for. The port has a fixed address and a fixed bank, both set by parameters. In an address cycle on its own bank it compares the bus byte with its address and records the outcome. Selection is sticky: it lasts through any number of data cycles until another address cycle on the same bank carries a different byte.

While selected, the port takes the bus byte into its output latch in a write cycle. In an input cycle it drives its input byte onto the bus in the same cycle. Address cycles on the other bank do not touch it, so each bank can keep one port active and the processor can switch between them with the bank line alone. The strobe combination with both strobes high is illegal and is ignored.

Selection is kept in a two-state machine. The states are `ST_IDLE` (not selected) and `ST_ACTIVE` (selected). The transition `ADDR_MATCH` goes from `ST_IDLE` to `ST_ACTIVE` on an address cycle on this bank whose bus byte equals the port address. The transition `ADDR_OTHER` goes from `ST_ACTIVE` to `ST_IDLE` on an address cycle on this bank with any other byte. Every other cycle holds the state (`HOLD`). Reset enters `ST_IDLE`.

Top module: `addr_bus_port`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `selected` is 0, `out_byte` is 0 and `drv_en` is 0.
- R2: An address cycle (`strobe_addr`=1, `strobe_wr`=0) with `bank_sel` equal to `PORT_BANK` and `bus_in` equal to `PORT_ADDR` sets `selected` to 1 from the next clock edge.
- R3: An address cycle on the port's bank with `bus_in` different from `PORT_ADDR` clears `selected` from the next clock edge.
- R4: Any cycle whose `bank_sel` differs from `PORT_BANK` leaves `selected` and `out_byte` unchanged and keeps `drv_en` at 0.
- R5: Write cycles (`strobe_addr`=0, `strobe_wr`=1) and input cycles (both strobes 0) leave `selected` unchanged, so one addressing serves any number of data cycles.
- R6: A write cycle on the port's bank while `selected` is 1 loads `bus_in` into `out_byte`, which is visible from the next edge.
- R7: A write cycle while `selected` is 0 leaves `out_byte` unchanged.
- R8: `drv_en` is 1 in the same cycle exactly when the cycle is an input cycle on the port's bank and `selected` is 1.
- R9: The illegal cycle (both strobes 1) changes neither `selected` nor `out_byte`, even when `bus_in` equals `PORT_ADDR`.
- R10: `bus_out` equals `in_byte` while `drv_en` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Byte present on the shared bus |
| strobe_addr | input | 1 | Address strobe; 1 with `strobe_wr`=0 marks an address cycle |
| strobe_wr | input | 1 | Write strobe; 1 with `strobe_addr`=0 marks an output-data cycle |
| bank_sel | input | 1 | Bank of the current cycle: 0 left, 1 right |
| in_byte | input | 8 | Byte the port returns in input cycles |
| drv_en | output | 1 | Bus drive enable; 0 means high impedance |
| bus_out | output | 8 | Byte driven on the bus when `drv_en` is 1 |
| out_byte | output | 8 | Output latch |
| selected | output | 1 | Port is currently addressed |

## Verification
The assertions assume that the strobes, bank line and bus byte are stable around each rising edge and that every cycle falls into exactly one of the four strobe codes, with the illegal code allowed as input. The stimulus changes inputs only on the falling edge. It draws strobe codes, banks and bytes at random, including the illegal code. Half of the address bytes are forced to the port address so that the port keeps entering and leaving selection. Directed sequences cover the reset state, other-bank addressing while selected, an illegal cycle that carries the port address, and writes while deselected.

// File: rtl/abp_pkg.sv
package abp_pkg;

    // Cycle kind, encoded as {strobe_addr, strobe_wr}
    typedef enum logic [1:0] {
        CYC_READ  = 2'b00,
        CYC_WRITE = 2'b01,
        CYC_ADDR  = 2'b10,
        CYC_BAD   = 2'b11
    } cyc_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } sel_state_e;

endpackage

// File: rtl/abp_decode.sv
module abp_decode
    import abp_pkg::*;
#(
    parameter int unsigned      DATA_W    = 8,
    parameter logic [DATA_W-1:0] PORT_ADDR = 8'hA5,
    parameter bit               PORT_BANK = 1'b0
) (
    input  logic [DATA_W-1:0] bus_in,
    input  logic              strobe_addr,
    input  logic              strobe_wr,
    input  logic              bank_sel,
    output cyc_e              cyc,
    output logic              bank_hit,
    output logic              addr_hit
);

    always_comb begin
        unique case ({strobe_addr, strobe_wr})
            2'b00:   cyc = CYC_READ;
            2'b01:   cyc = CYC_WRITE;
            2'b10:   cyc = CYC_ADDR;
            default: cyc = CYC_BAD;
        endcase
    end

    assign bank_hit = (bank_sel == PORT_BANK);
    assign addr_hit = (bus_in == PORT_ADDR);

endmodule

// File: rtl/abp_select_fsm.sv
module abp_select_fsm
    import abp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cyc_e cyc,
    input  logic bank_hit,
    input  logic addr_hit,
    output logic selected
);

    sel_state_e state_q, state_d;

    // Next-state logic: ADDR_MATCH, ADDR_OTHER, HOLD
    always_comb begin
        state_d = state_q;
        if (cyc == CYC_ADDR && bank_hit) begin
            unique case (state_q)
                ST_IDLE:   if (addr_hit)  state_d = ST_ACTIVE;
                ST_ACTIVE: if (!addr_hit) state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   selected = 1'b0;
            ST_ACTIVE: selected = 1'b1;
        endcase
    end

    assert_addr_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_ADDR && bank_hit && addr_hit) |=> selected);

    assert_addr_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_ADDR && bank_hit && !addr_hit) |=> !selected);

    assert_other_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_hit) |=> $stable(selected));

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_READ || cyc == CYC_WRITE) |=> $stable(selected));

    assert_illegal_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_BAD) |=> $stable(selected));

endmodule

// File: rtl/abp_out_latch.sv
module abp_out_latch
    import abp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              cyc,
    input  logic              bank_hit,
    input  logic              selected,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] out_byte
);

    logic load;

    assign load = (cyc == CYC_WRITE) && bank_hit && selected;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_byte <= '0;
        else if (load) out_byte <= bus_in;
    end

    assert_write_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WRITE && bank_hit && selected) |=> (out_byte == $past(bus_in)));

    assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!selected) |=> $stable(out_byte));

    assert_illegal_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_BAD || !bank_hit) |=> $stable(out_byte));

endmodule

// File: rtl/addr_bus_port.sv
module addr_bus_port
    import abp_pkg::*;
#(
    parameter int unsigned       DATA_W    = 8,
    parameter logic [DATA_W-1:0] PORT_ADDR = 8'hA5,
    parameter bit                PORT_BANK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              strobe_addr,
    input  logic              strobe_wr,
    input  logic              bank_sel,
    input  logic [DATA_W-1:0] in_byte,
    output logic              drv_en,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] out_byte,
    output logic              selected
);

    cyc_e cyc;
    logic bank_hit;
    logic addr_hit;

    abp_decode #(
        .DATA_W    (DATA_W),
        .PORT_ADDR (PORT_ADDR),
        .PORT_BANK (PORT_BANK)
    ) u_decode (
        .bus_in      (bus_in),
        .strobe_addr (strobe_addr),
        .strobe_wr   (strobe_wr),
        .bank_sel    (bank_sel),
        .cyc         (cyc),
        .bank_hit    (bank_hit),
        .addr_hit    (addr_hit)
    );

    abp_select_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (cyc),
        .bank_hit (bank_hit),
        .addr_hit (addr_hit),
        .selected (selected)
    );

    abp_out_latch #(
        .DATA_W (DATA_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (cyc),
        .bank_hit (bank_hit),
        .selected (selected),
        .bus_in   (bus_in),
        .out_byte (out_byte)
    );

    always_comb begin
        drv_en  = selected && bank_hit && (cyc == CYC_READ);
        bus_out = drv_en ? in_byte : '0;
    end

    always_comb begin
        if (!rst_n) assert_reset_R1: assert (!selected && out_byte == '0 && !drv_en);
        if (!drv_en) assert_quiet_bus_R10: assert (bus_out == '0);
    end

    assert_drive_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (selected && !strobe_addr && !strobe_wr && bank_sel == PORT_BANK));

endmodule

// File: tb/tb_addr_bus_port.sv
module tb_addr_bus_port;

    localparam logic [7:0] ADDR = 8'hA5;
    localparam bit         BANK = 1'b0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = '0;
    logic       strobe_addr = 1'b0;
    logic       strobe_wr = 1'b0;
    logic       bank_sel = 1'b0;
    logic [7:0] in_byte = '0;
    logic       drv_en;
    logic [7:0] bus_out;
    logic [7:0] out_byte;
    logic       selected;

    int checks = 0;
    int errors = 0;
    logic       m_sel = 1'b0;
    logic [7:0] m_lat = '0;

    always #5 clk = ~clk;

    addr_bus_port #(.DATA_W(8), .PORT_ADDR(ADDR), .PORT_BANK(BANK)) dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .strobe_addr(strobe_addr),
        .strobe_wr(strobe_wr), .bank_sel(bank_sel), .in_byte(in_byte),
        .drv_en(drv_en), .bus_out(bus_out), .out_byte(out_byte), .selected(selected)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_drive(input logic sc, input logic wc, input logic bk, input logic sel);
        return sel && !sc && !wc && (bk == BANK);
    endfunction

    function automatic string sel_tag(input logic sc, input logic wc, input logic bk, input logic [7:0] b);
        if (sc && wc)   return "R9";
        if (bk != BANK) return "R4";
        if (sc)         return (b == ADDR) ? "R2" : "R3";
        return "R5";
    endfunction

    function automatic string lat_tag(input logic sc, input logic wc, input logic bk, input logic sel);
        if (sc && wc)   return "R9";
        if (bk != BANK) return "R4";
        if (wc && sel)  return "R6";
        return "R7";
    endfunction

    task automatic cycle(input logic sc, input logic wc, input logic bk, input logic [7:0] b, input logic [7:0] ib);
        logic d;
        @(negedge clk);
        strobe_addr = sc; strobe_wr = wc; bank_sel = bk; bus_in = b; in_byte = ib;
        #1;
        d = exp_drive(sc, wc, bk, m_sel);
        check(d ? "R8" : "R4", "drv_en", {7'b0, drv_en}, {7'b0, d});
        check("R10", "bus_out", bus_out, d ? ib : 8'h00);
        @(posedge clk);
        if (!(sc && wc) && bk == BANK) begin
            if (sc && !wc)      m_sel = (b == ADDR);
            else if (wc && m_sel) m_lat = b;
        end
        #1;
        check(sel_tag(sc, wc, bk, b), "selected", {7'b0, selected}, {7'b0, m_sel});
        check(lat_tag(sc, wc, bk, m_sel), "out_byte", out_byte, m_lat);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h0BADC0DE));
        // R1: reset state
        repeat (2) @(negedge clk);
        #1;
        check("R1", "selected", {7'b0, selected}, 8'h00);
        check("R1", "out_byte", out_byte, 8'h00);
        check("R1", "drv_en", {7'b0, drv_en}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: write while deselected is ignored
        cycle(1'b0, 1'b1, BANK, 8'h3C, 8'h00);
        // R9: illegal cycle with own address does not select
        cycle(1'b1, 1'b1, BANK, ADDR, 8'h00);
        // R2: select, R6: write, R8: read
        cycle(1'b1, 1'b0, BANK, ADDR, 8'h00);
        cycle(1'b0, 1'b1, BANK, 8'h5A, 8'h00);
        cycle(1'b0, 1'b0, BANK, 8'h00, 8'hC3);
        // R4: other-bank address leaves selection, other-bank write ignored
        cycle(1'b1, 1'b0, ~BANK, 8'h11, 8'h00);
        cycle(1'b0, 1'b1, ~BANK, 8'h77, 8'h00);
        cycle(1'b0, 1'b0, ~BANK, 8'h00, 8'h99);
        // R5: repeated data cycles without re-addressing
        repeat (4) cycle(1'b0, 1'b1, BANK, 8'hE1, 8'h00);
        cycle(1'b0, 1'b0, BANK, 8'h00, 8'h42);
        // R9: illegal while selected, R3: other address deselects
        cycle(1'b1, 1'b1, BANK, 8'h00, 8'h00);
        cycle(1'b1, 1'b0, BANK, 8'h12, 8'h00);
        cycle(1'b0, 1'b0, BANK, 8'h00, 8'h66);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] code;
            logic       bk;
            logic [7:0] b;
            code = 2'($urandom_range(0, 3));
            bk   = ($urandom_range(0, 3) == 0) ? ~BANK : BANK;
            b    = 8'($urandom);
            if (code[1] && $urandom_range(0, 1) == 1) b = ADDR;
            cycle(code[1], code[0], bk, b, 8'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule